// File: doc/BRIEF.md
# SMBus Transaction Sequencer

This block is the command core of a mailbox-style SMBus host. Software fills a small byte-wide register file with the target address, the command byte, the byte count and up to 32 data bytes. A single write of a protocol code to offset 0x00 then starts a complete SMBus transaction. The sequencer turns that code into an ordered list of byte-level bus operations: start, repeated start, send a byte and check its acknowledge, receive a byte and answer ACK or NACK, and stop. It hands each operation to a separate bit-level engine through a request/done handshake.

When the transaction ends, any bytes read from the target are in the data buffer, and the status register shows a done flag and a numeric result code. An optional packet error code (CRC-8) can be added to the transaction. The sequencer computes it over every byte on the bus, appends it on writes and checks it on reads.

Top module: `smbus_seq`

## Requirements
- R1: After reset every register reads 0x00. Register offsets: 0x00 protocol, 0x01 status (bit 7 done, bit 6 alarm always 0, bits 4:0 result), 0x02 address (7-bit address in bits 7:1), 0x03 command, 0x04..0x23 data bytes 0..31, 0x24 count. Other offsets read 0.
- R2: While idle, writing offset 0x00 stores the code, clears done and the result, and starts the transaction. While a transaction runs, writes to offsets other than 0x00 are ignored. The status register can never be written.
- R3: The protocol byte uses bit 0 for read, bit 7 for PEC and bits 6:1 for the type: 0x02 quick, 0x04 byte, 0x06 byte data, 0x08 word data, 0x0A block, 0x0C process call, 0x0D block process call, 0x4A raw block. Each type produces its fixed operation order. Address bytes carry the read/write bit in bit 0. Every transaction that reaches the bus ends with a stop.
- R4: Word data is little-endian: data byte 0 goes on the bus (or is stored) first. A process call writes two bytes, sends a repeated start and reads two bytes.
- R5: Block writes send the count byte and then that many data bytes. Block reads store the received count at 0x24. Raw block transfers send no count byte and take their length from 0x24. A block process call writes a block and then reads one back.
- R6: Every received byte is acknowledged, except the last byte of the transaction, which is NACKed.
- R7: A NACK on an address byte ends the transaction with a stop and result 0x10. A NACK on any later sent byte ends it with a stop and result 0x11.
- R8: A received block count of 0 or above 32 ends the transaction with a stop and result 0x11. The count register is left unchanged.
- R9: With bit 7 set (not for quick or raw block), a CRC-8 (x^8+x^2+x+1, initial value 0) covers every address, command, count and data byte. It is sent after the last written byte, or received (with NACK) after the last read byte. A mismatch gives result 0x1F.
- R10: Writing offset 0x00 while busy sets the result to 0x1A. It does not change the stored code, and the running transaction continues and sets its own final result.
- R11: An unknown type, a block write or raw block count outside 1..32, or a block process call count outside 1..31 completes at once with result 0x07 and no bus operation.
- R12: If the engine does not answer a request within TIMEOUT_CYCLES cycles, the transaction ends with done set and result 0x18, without a stop.
- R13: Each bus operation is a one-cycle request with the operation code (0 start, 1 stop, 2 send, 3 receive+ACK, 4 receive+NACK) held stable until done. Done is accepted no earlier than one cycle after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 6 | Register offset for read and write |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational from reg_addr) |
| eng_req | output | 1 | One-cycle request for a bus operation |
| eng_op | output | 3 | Operation code of the current request |
| eng_wbyte | output | 8 | Byte to send for a send operation |
| eng_done | input | 1 | Engine finished the requested operation |
| eng_nack | input | 1 | With done on a send: the target did not acknowledge |
| eng_rbyte | input | 8 | With done on a receive: the byte received |

## Verification
The assertions assume the engine raises done for a single cycle, never in the cycle of the request itself, and only for a request that is still open. The bench's engine model waits one to three cycles before answering each request and stays silent while it is told to stall. The only done it gives with no request pending comes after the timeout case, when the sequencer is idle and must ignore it. Register writes come only from the bench's write task, one per two cycles, so a launch and a busy write are never merged into one cycle.

// File: rtl/smbus_seq.sv
`timescale 1ns/1ps
module smbus_seq #(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_we,
  input  logic [5:0] reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       eng_req,
  output logic [2:0] eng_op,
  output logic [7:0] eng_wbyte,
  input  logic       eng_done,
  input  logic       eng_nack,
  input  logic [7:0] eng_rbyte
);
  localparam int TW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [2:0] OP_START = 3'd0, OP_STOP = 3'd1, OP_SEND = 3'd2,
                         OP_RACK = 3'd3, OP_RNAK = 3'd4;

  typedef enum logic [3:0] {
    S_IDLE, S_CHECK, S_START, S_ADDR1, S_CMD, S_WCNT, S_WDATA,
    S_RSTART, S_ADDR2, S_RCNT, S_RDATA, S_PECTX, S_PECRX, S_STOP
  } st_t;

  st_t         st;
  logic [7:0]  proto, addr, cmd, cnt, crc;
  logic [7:0]  dbuf [32];
  logic [4:0]  code, res, idx;
  logic [5:0]  len;
  logic [TW-1:0] tmr;
  logic        done, waiting, busy, last;

  function automatic logic [7:0] crc_step(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] x;
    x = c ^ d;
    for (int i = 0; i < 8; i++) x = x[7] ? ((x << 1) ^ 8'h07) : (x << 1);
    return x;
  endfunction

  wire [7:0] pk     = proto & 8'h7E;
  wire       rd     = proto[0];
  wire       is_q   = pk == 8'h02;
  wire       is_b   = pk == 8'h04;
  wire       is_bd  = pk == 8'h06;
  wire       is_w   = pk == 8'h08;
  wire       is_blk = pk == 8'h0A;
  wire       is_pc  = pk == 8'h0C && !rd;
  wire       is_bpc = pk == 8'h0C && rd;
  wire       is_i2c = pk == 8'h4A;
  wire       pec_on = proto[7] && !is_q && !is_i2c;
  wire       ok32   = cnt != 8'd0 && cnt <= 8'd32;
  wire       ok31   = cnt != 8'd0 && cnt <= 8'd31;
  wire       valid  = is_q || is_b || is_bd || is_w || is_pc || (is_blk && (rd || ok32))
                      || (is_bpc && ok31) || (is_i2c && ok32);
  wire [5:0] xlen   = (is_b || is_bd) ? 6'd1 : (is_w || is_pc) ? 6'd2 : cnt[5:0];
  wire st_t  tail   = pec_on ? S_PECTX : S_STOP;

  assign busy    = st != S_IDLE;
  assign last    = ({1'b0, idx} + 6'd1) == len;
  assign eng_req = busy && st != S_CHECK && !waiting;

  always_comb begin
    case (st)
      S_START, S_RSTART: eng_op = OP_START;
      S_STOP:            eng_op = OP_STOP;
      S_RCNT:            eng_op = OP_RACK;
      S_RDATA:           eng_op = (last && !pec_on) ? OP_RNAK : OP_RACK;
      S_PECRX:           eng_op = OP_RNAK;
      default:           eng_op = OP_SEND;
    endcase
    case (st)
      S_ADDR1: eng_wbyte = {addr[7:1], is_q ? rd : (is_b && rd)};
      S_CMD:   eng_wbyte = cmd;
      S_WCNT:  eng_wbyte = cnt;
      S_WDATA: eng_wbyte = dbuf[idx];
      S_ADDR2: eng_wbyte = {addr[7:1], 1'b1};
      S_PECTX: eng_wbyte = crc;
      default: eng_wbyte = 8'h00;
    endcase
  end

  always_comb begin
    reg_rdata = 8'h00;
    if (reg_addr == 6'h00)      reg_rdata = proto;
    else if (reg_addr == 6'h01) reg_rdata = {done, 2'b00, code};
    else if (reg_addr == 6'h02) reg_rdata = addr;
    else if (reg_addr == 6'h03) reg_rdata = cmd;
    else if (reg_addr == 6'h24) reg_rdata = cnt;
    else if (reg_addr >= 6'h04 && reg_addr <= 6'h23) reg_rdata = dbuf[5'(reg_addr - 6'd4)];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; proto <= '0; addr <= '0; cmd <= '0; cnt <= '0; crc <= '0;
      code <= '0; res <= '0; idx <= '0; len <= '0; tmr <= '0; done <= 1'b0; waiting <= 1'b0;
      for (int i = 0; i < 32; i++) dbuf[i] <= '0;
    end else begin
      if (reg_we) begin
        if (reg_addr == 6'h00) begin
          if (!busy) begin
            proto <= reg_wdata; done <= 1'b0; code <= '0; res <= '0; crc <= '0;
            waiting <= 1'b0; st <= S_CHECK;
          end else code <= 5'h1A;
        end else if (!busy) begin
          if (reg_addr == 6'h02)      addr <= reg_wdata;
          else if (reg_addr == 6'h03) cmd  <= reg_wdata;
          else if (reg_addr == 6'h24) cnt  <= reg_wdata;
          else if (reg_addr >= 6'h04 && reg_addr <= 6'h23) dbuf[5'(reg_addr - 6'd4)] <= reg_wdata;
        end
      end
      if (st == S_CHECK) begin
        if (!valid) begin st <= S_IDLE; done <= 1'b1; code <= 5'h07; end
        else st <= S_START;
      end else if (busy) begin
        if (!waiting) begin
          waiting <= 1'b1; tmr <= '0;
        end else if (eng_done) begin
          waiting <= 1'b0;
          if (st inside {S_ADDR1, S_CMD, S_WCNT, S_WDATA, S_ADDR2, S_RCNT, S_RDATA})
            crc <= crc_step(crc, eng_op == OP_SEND ? eng_wbyte : eng_rbyte);
          if (eng_nack && eng_op == OP_SEND) begin
            res <= (st == S_ADDR1 || st == S_ADDR2) ? 5'h10 : 5'h11;
            st  <= S_STOP;
          end else begin
            case (st)
              S_START:  st <= S_ADDR1;
              S_ADDR1:  if (is_q) st <= S_STOP;
                        else if (is_b && rd) begin idx <= '0; len <= 6'd1; st <= S_RDATA; end
                        else st <= S_CMD;
              S_CMD:    if (is_b) st <= tail;
                        else if ((is_blk && !rd) || is_bpc) st <= S_WCNT;
                        else if ((!rd && (is_bd || is_w || is_i2c)) || is_pc) begin
                          idx <= '0; len <= xlen; st <= S_WDATA;
                        end else st <= S_RSTART;
              S_WCNT:   begin idx <= '0; len <= xlen; st <= S_WDATA; end
              S_WDATA:  if (last) st <= (is_pc || is_bpc) ? S_RSTART : tail;
                        else idx <= idx + 5'd1;
              S_RSTART: st <= S_ADDR2;
              S_ADDR2:  if (is_blk || is_bpc) st <= S_RCNT;
                        else begin idx <= '0; len <= xlen; st <= S_RDATA; end
              S_RCNT:   if (eng_rbyte == 8'd0 || eng_rbyte > 8'd32) begin res <= 5'h11; st <= S_STOP; end
                        else begin cnt <= eng_rbyte; len <= eng_rbyte[5:0]; idx <= '0; st <= S_RDATA; end
              S_RDATA:  begin
                          dbuf[idx] <= eng_rbyte;
                          if (last) st <= pec_on ? S_PECRX : S_STOP;
                          else idx <= idx + 5'd1;
                        end
              S_PECTX:  st <= S_STOP;
              S_PECRX:  begin if (eng_rbyte != crc) res <= 5'h1F; st <= S_STOP; end
              S_STOP:   begin st <= S_IDLE; done <= 1'b1; code <= res; end
              default:  st <= S_IDLE;
            endcase
          end
        end else if (tmr == TW'(TIMEOUT_CYCLES - 1)) begin
          st <= S_IDLE; done <= 1'b1; code <= 5'h18; waiting <= 1'b0;
        end else tmr <= tmr + 1'b1;
      end
    end
  end
endmodule

module smbus_seq_chk #(
  parameter int TIMEOUT_CYCLES = 4096
) (
  input logic       clk,
  input logic       rst_n,
  input logic       reg_we,
  input logic [5:0] reg_addr,
  input logic       eng_req,
  input logic [2:0] eng_op,
  input logic       eng_done,
  input logic       busy,
  input logic       done,
  input logic [4:0] code,
  input logic [7:0] proto
);
  int unsigned wait_cnt;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) wait_cnt <= 0;
    else if (!busy || eng_req) wait_cnt <= 0;
    else wait_cnt <= wait_cnt + 1;

  // R13
  req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) eng_req |=> !eng_req);
  // R13
  op_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) eng_req |=> $stable(eng_op));
  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !eng_req);
  // R2
  launch_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 6'h00 && !busy) |=> (!done && code == 5'h00 && busy));
  // R10
  busy_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 6'h00 && busy) |=> (code == 5'h1A || done));
  // R10
  busy_keep_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == 6'h00 && busy) |=> $stable(proto));
  // R3
  stop_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(done) && code != 5'h18 && code != 5'h07) |-> $past(eng_op) == 3'd1);
  // R12
  wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> wait_cnt <= TIMEOUT_CYCLES + 2);
endmodule

bind smbus_seq smbus_seq_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .eng_req(eng_req),
  .eng_op(eng_op), .eng_done(eng_done), .busy(busy), .done(done), .code(code), .proto(proto)
);

// File: tb/tb_smbus_seq.sv
`timescale 1ns/1ps
module tb_smbus_seq;
  localparam int TMO = 64;
  localparam int START = 0, STOP = 1, SEND = 2, RACK = 3, RNAK = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [5:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0, reg_rdata;
  logic eng_req, eng_done, eng_nack;
  logic [2:0] eng_op;
  logic [7:0] eng_wbyte, eng_rbyte;

  smbus_seq #(.TIMEOUT_CYCLES(TMO)) dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .eng_req(eng_req), .eng_op(eng_op), .eng_wbyte(eng_wbyte),
    .eng_done(eng_done), .eng_nack(eng_nack), .eng_rbyte(eng_rbyte));

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  int log_op[100], log_b[100], log_n = 0, rx_i = 0, nack_at = 999;
  int exp_op[100], exp_b[100], exp_n, exp_code, exp_cnt, exp_rn, rxi;
  int rx[100];
  logic [7:0] wbuf[32], exp_rd[32], crc_e;
  bit ab, stall = 1'b0, reading;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] crc8(input logic [7:0] c, input logic [7:0] d);
    logic [7:0] r = c;
    for (int b = 7; b >= 0; b--) begin
      bit fb = r[7] ^ d[b];
      r = {r[6:0], 1'b0};
      if (fb) r = r ^ 8'h07;
    end
    return r;
  endfunction

  // bit-level engine model
  initial begin
    eng_done = 1'b0; eng_nack = 1'b0; eng_rbyte = 8'h00;
    forever begin
      @(negedge clk);
      eng_done = 1'b0; eng_nack = 1'b0;
      if (eng_req) begin
        int op, n;
        op = int'(eng_op); n = log_n;
        if (n < 100) begin log_op[n] = op; log_b[n] = (op == SEND) ? int'(eng_wbyte) : 0; end
        log_n++;
        repeat (1 + $urandom % 3) @(negedge clk);
        while (stall) @(negedge clk);
        eng_done = 1'b1;
        eng_nack = (op == SEND && n == nack_at);
        if (op == RACK || op == RNAK) begin eng_rbyte = 8'(rx[rx_i % 100]); rx_i++; end
      end
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = 6'(a); reg_wdata = 8'(d);
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    reg_addr = 6'(a);
    #1 v = int'(reg_rdata);
  endtask

  task automatic wait_done(output int st);
    int k = 0;
    st = 0;
    while (k < 5000) begin
      @(negedge clk);
      rd(1, st);
      if (st[7]) break;
      k++;
    end
    if (!st[7]) chk(1'b0, "R3", "done never set", st, 128);
  endtask

  task automatic push(input int op, input int b, input bit is_addr);
    if (ab) return;
    exp_op[exp_n] = op; exp_b[exp_n] = (op == SEND) ? b : 0;
    if (op == SEND && exp_n == nack_at) begin ab = 1; exp_code = is_addr ? 'h10 : 'h11; end
    exp_n++;
  endtask

  task automatic snd(input int b, input bit is_addr);
    if (ab) return;
    push(SEND, b, is_addr);
    crc_e = crc8(crc_e, 8'(b));
  endtask

  task automatic rcv(input bit lst, output logic [7:0] v);
    v = 8'h00;
    if (ab) return;
    v = 8'(rx[rxi]);
    push(lst ? RNAK : RACK, 0, 0);
    rxi++;
    crc_e = crc8(crc_e, v);
  endtask

  // expected bus sequence and result from the requirements
  task automatic build(input int p, input int a, input int c, input int cnt, input int rc, input bit bad);
    int k, n;
    bit r, pe, pc, bpc;
    logic [7:0] v;
    k = p & 'h7E; r = p[0]; pe = p[7] && k != 2 && k != 'h4A;
    pc = (k == 'h0C) && !r; bpc = (k == 'h0C) && r;
    exp_n = 0; ab = 0; exp_code = 0; crc_e = 0; rxi = 0; exp_rn = 0; exp_cnt = cnt; reading = 0;
    for (int i = 0; i < 100; i++) rx[i] = $urandom % 256;
    push(START, 0, 0);
    if (k == 2) snd((a & 'hFE) | r, 1);
    else if (k == 4 && r) begin
      reading = 1; snd(a | 1, 1); rcv(!pe, v); exp_rd[0] = v; exp_rn = 1;
    end else begin
      snd(a & 'hFE, 1); snd(c, 0);
      if (k == 6 && !r) snd(wbuf[0], 0);
      if ((k == 8 && !r) || pc) begin snd(wbuf[0], 0); snd(wbuf[1], 0); end
      if ((k == 'h0A && !r) || bpc) begin snd(cnt, 0); for (int i = 0; i < cnt; i++) snd(wbuf[i], 0); end
      if (k == 'h4A && !r) for (int i = 0; i < cnt; i++) snd(wbuf[i], 0);
      if ((r && (k == 6 || k == 8 || k == 'h0A || k == 'h4A)) || pc || bpc) begin
        reading = 1;
        push(START, 0, 0); snd(a | 1, 1);
        n = (k == 6) ? 1 : (k == 8 || pc) ? 2 : (k == 'h4A) ? cnt : rc;
        if (k == 'h0A || bpc) begin
          if (!ab) rx[rxi] = rc;
          rcv(1'b0, v);
          if (!ab) begin
            if (rc == 0 || rc > 32) begin ab = 1; exp_code = 'h11; end
            else exp_cnt = rc;
          end
        end
        if (!ab) begin
          for (int i = 0; i < n; i++) begin rcv(i == n - 1 && !pe, v); exp_rd[i] = v; end
          exp_rn = n;
        end
      end
    end
    if (pe && !ab) begin
      if (reading) begin
        rx[rxi] = int'(crc_e ^ (bad ? 8'h5A : 8'h00));
        rcv(1'b1, v);
        if (bad) exp_code = 'h1F;
      end else snd(crc_e, 0);
    end
    exp_op[exp_n] = STOP; exp_b[exp_n] = 0; exp_n++;
  endtask

  task automatic load(input int a, input int c, input int cnt);
    for (int i = 0; i < 32; i++) wbuf[i] = 8'($urandom);
    wr(2, a); wr(3, c); wr('h24, cnt);
    for (int i = 0; i < 32; i++) wr(4 + i, wbuf[i]);
  endtask

  task automatic compare(input int st, input int c);
    int bad_i = -1, v;
    chk(st[4:0] == exp_code[4:0], "R7", "result code", st[4:0], exp_code);
    for (int i = 0; i < exp_n; i++)
      if (bad_i < 0 && (log_op[i] != exp_op[i] || log_b[i] != exp_b[i])) bad_i = i;
    // R3 R4 R5 R6 R9: operation order, bytes and ack choice
    chk(log_n == exp_n && bad_i < 0, "R3", "bus sequence step",
        (bad_i < 0) ? log_n : log_op[bad_i] * 256 + log_b[bad_i],
        (bad_i < 0) ? exp_n : exp_op[bad_i] * 256 + exp_b[bad_i]);
    if (exp_code == 0 && reading) begin
      bad_i = -1;
      for (int i = 0; i < exp_rn; i++) begin rd(4 + i, v); if (bad_i < 0 && v != int'(exp_rd[i])) bad_i = i; end
      chk(bad_i < 0, "R4", "read data buffer", bad_i, -1);
    end
    rd('h24, v);
    chk(v == exp_cnt, "R5", "count register", v, exp_cnt);
    rd(0, v);
    chk(v == c, "R2", "protocol register", v, c);
  endtask

  task automatic run(input int p, input int a, input int c, input int cnt, input int rc, input bit bad, input int nk);
    int st;
    nack_at = nk;
    load(a, c, cnt);
    build(p, a, c, cnt, rc, bad);
    log_n = 0; rx_i = 0;
    wr(0, p);
    wait_done(st);
    compare(st, p);
  endtask

  task automatic run_bad(input int p, input int cnt);
    int st;
    nack_at = 999;
    wr('h24, cnt);
    log_n = 0;
    wr(0, p);
    wait_done(st);
    repeat (4) @(negedge clk);
    // R11
    chk(st[4:0] == 5'h07, "R11", "invalid launch code", st[4:0], 7);
    chk(log_n == 0, "R11", "bus ops on invalid launch", log_n, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int v, st, bad_i;
    int codes[14] = '{'h02, 'h03, 'h04, 'h05, 'h06, 'h07, 'h08, 'h09, 'h0A, 'h0B, 'h0C, 'h0D, 'h4A, 'h4B};
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset values
    bad_i = -1;
    for (int i = 0; i < 64; i++) begin rd(i, v); if (bad_i < 0 && v != 0) bad_i = i; end
    chk(bad_i < 0, "R1", "nonzero register after reset at offset", bad_i, -1);

    // R3 quick write and read, PEC bit ignored on quick (R9)
    run('h02, 'hA4, 0, 1, 0, 0, 999);
    run('h83, 'h3C, 0, 1, 0, 0, 999);
    // R7 address NACK, then data NACK
    run('h06, 'h50, 'h12, 1, 0, 0, 1);
    run('h08, 'h50, 'h12, 1, 0, 0, 3);
    // R4 word read and process call
    run('h09, 'h22, 'h07, 1, 0, 0, 999);
    run('h0C, 'h22, 'h07, 1, 0, 0, 999);
    // R5 block write at 32, block read 32, raw block read
    run('h0A, 'h90, 'h44, 32, 0, 0, 999);
    run('h0B, 'h90, 'h44, 5, 32, 0, 999);
    run('h4B, 'h90, 'h44, 6, 0, 0, 999);
    run('h0D, 'h90, 'h44, 31, 3, 0, 999);
    // R8 received count 0 and 33
    run('h0B, 'h90, 'h44, 9, 0, 0, 999);
    run('h0D, 'h90, 'h44, 4, 33, 0, 999);
    // R9 PEC good write, good read, bad read; raw block ignores PEC
    run('h8A, 'h30, 'h01, 7, 0, 0, 999);
    run('h89, 'h30, 'h01, 1, 0, 0, 999);
    run('h89, 'h30, 'h01, 1, 0, 1, 999);
    run('h8B, 'h30, 'h01, 1, 12, 1, 999);
    run('hCA, 'h30, 'h01, 3, 0, 0, 999);
    // R6 single byte read ends with NACK
    run('h05, 'h6E, 0, 1, 0, 0, 999);

    // R11 invalid launches
    run_bad('h0E, 1);
    run_bad('h0A, 0);
    run_bad('h0D, 32);
    run_bad('h4A, 33);

    // R10 and R2: writes during a running transaction
    nack_at = 999;
    load('hB2, 'h5D, 32);
    build('h0A, 'hB2, 'h5D, 32, 0, 0);
    log_n = 0; rx_i = 0;
    wr(0, 'h0A);
    repeat (6) @(negedge clk);
    wr(0, 'h08);
    wr(2, 'h11);
    wr('h24, 3);
    rd(1, v);
    // R10 busy code visible while running
    chk(v == 'h1A, "R10", "status during busy write", v, 'h1A);
    wait_done(st);
    compare(st, 'h0A);
    rd(2, v);
    // R2 address write ignored while busy
    chk(v == 'hB2, "R2", "address after busy write", v, 'hB2);
    wr(1, 'h55);
    rd(1, v);
    // R2 status is read-only
    chk(v == 'h80, "R2", "status after write attempt", v, 'h80);

    // R12 engine stall
    stall = 1'b1;
    log_n = 0;
    wr(0, 'h02);
    wait_done(st);
    chk(st[4:0] == 5'h18, "R12", "timeout result", st[4:0], 'h18);
    chk(log_n == 1, "R12", "ops before timeout", log_n, 1);
    stall = 1'b0;
    repeat (10) @(negedge clk);

    // random mix (R3 R4 R5 R6 R7 R9)
    for (int t = 0; t < 60; t++) begin
      int p, cnt, rc, nk, k;
      p = codes[$urandom % 14] | (($urandom % 2) ? 'h80 : 0);
      k = p & 'h7E;
      cnt = (k == 'h0C && p[0]) ? 1 + $urandom % 31 : 1 + $urandom % 32;
      rc = 1 + $urandom % 32;
      nk = ($urandom % 6 == 0) ? $urandom % 6 : 999;
      run(p, $urandom % 256, $urandom % 256, cnt, rc, ($urandom % 5) == 0, nk);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule